// File: doc/BRIEF.md
# Cartridge DMA Control Register Bank

This block is the software-visible front end of a cartridge-bus DMA engine. It holds the DRAM-side address, the cartridge-side address, the two transfer lengths, a status/command word and a timing setting for the first cartridge domain. Software reaches these registers over a simple 32-bit bus. Each write carries four byte-lane enables, and a write updates only the lanes that are enabled. The engine reads the address and length values straight from the output ports.

A write to a length register is itself the start command. A write to the read-length slot starts a DRAM-to-cartridge transfer, and a write to the write-length slot starts a cartridge-to-DRAM transfer. On either one the block emits a one-cycle start pulse and raises its busy flag. When the engine signals completion, busy drops, the interrupt-pending flag is set and the interrupt line toward the system interrupt controller goes high. The interrupt stays pending until software acknowledges it through the command word.

Top module: `pdma_regs`

## Requirements
- R1: After reset the DRAM address, cartridge address, domain timing and status all read as zero, both length registers read 0x0000007F, and irq, start_rd and start_wr are low.
- R2: Every register write computes new = (old & ~m) | (wdata & m), where m is the 32-bit mask built by repeating req_be[k] over byte k (bits 8k+7..8k).
- R3: The DRAM address register (offset 0x00) is masked with 0x00FFFFFE after each write, so bit 0 and bits 31..24 always read zero.
- R4: The cartridge address register (offset 0x04) has bit 0 forced to zero on a write when allow_odd is low, and keeps the written bit 0 when allow_odd is high.
- R5: Both length registers keep only their low 24 bits. An accepted write to offset 0x08 updates the read length, pulses start_rd high for exactly the one cycle after the write edge and sets busy. An accepted write to offset 0x0C does the same with start_wr and the write length.
- R6: A length write that arrives while busy is set leaves the length register unchanged and produces no start pulse.
- R7: A dma_done pulse while busy clears busy, sets the interrupt-pending bit and drives irq high from the next cycle. A dma_done pulse while idle has no effect.
- R8: A write to offset 0x10 with lane 0 enabled and wdata bit 1 set clears the interrupt-pending bit and drops irq. A completion in the same cycle takes precedence.
- R9: A write to offset 0x10 with lane 0 enabled and wdata bit 0 set clears busy without setting the interrupt-pending bit.
- R10: Reading offset 0x10 returns the status word zero-extended to 32 bits, with bit 0 = DMA busy, bit 1 = IO busy, bit 2 = error and bit 3 = interrupt pending. IO busy and error always read zero. Unmapped offsets read zero, and writes to them change nothing.
- R11: The domain-1 timing register (offset 0x14) keeps only its low 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_wr | input | 1 | Register write strobe |
| req_addr | input | 5 | Byte offset of the register access (bits 4..2 select the register) |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane write enables |
| allow_odd | input | 1 | Permit an odd cartridge address |
| dma_done | input | 1 | Transfer completion pulse from the engine |
| rdata | output | 32 | Read data for req_addr (combinational) |
| dram_addr | output | 32 | DRAM address toward the engine |
| cart_addr | output | 32 | Cartridge address toward the engine |
| rd_len | output | 24 | DRAM-to-cartridge length |
| wr_len | output | 24 | Cartridge-to-DRAM length |
| dom1_timing | output | 8 | Domain-1 timing setting |
| start_rd | output | 1 | One-cycle start of a DRAM-to-cartridge transfer |
| start_wr | output | 1 | One-cycle start of a cartridge-to-DRAM transfer |
| irq | output | 1 | Interrupt request, high while an interrupt is pending |

## Verification
The assertions watch the handshake with the engine on every cycle. They check that a start pulse lasts one cycle and always comes with busy set, that a length write during busy neither pulses nor changes the length, that a completion raises irq and drops busy, and that the acknowledge and abort commands take effect on the next cycle. The register contents need the bench's reference model, which tracks the byte-lane merging, the per-register masks, the effect of allow_odd, the reset values and the zero read-back of unmapped offsets. Only random sequences of writes, completions and commands can show that these stay right across many interleavings.

// File: rtl/pdma_regs.sv
module pdma_regs #(
  parameter int               LEN_W   = 24,
  parameter logic [LEN_W-1:0] LEN_RST = 'h7F,
  parameter int               DOM_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic [4:0]       req_addr,
  input  logic [31:0]      req_wdata,
  input  logic [3:0]       req_be,
  input  logic             allow_odd,
  input  logic             dma_done,
  output logic [31:0]      rdata,
  output logic [31:0]      dram_addr,
  output logic [31:0]      cart_addr,
  output logic [LEN_W-1:0] rd_len,
  output logic [LEN_W-1:0] wr_len,
  output logic [DOM_W-1:0] dom1_timing,
  output logic             start_rd,
  output logic             start_wr,
  output logic             irq
);
  localparam logic [31:0] DRAM_MASK = 32'h00FF_FFFE;
  localparam int          LPAD      = 32 - LEN_W;
  localparam int          DPAD      = 32 - DOM_W;

  logic [31:0] lane_m;
  logic [2:0]  sel;
  logic        busy, intr;
  logic        hit_dram, hit_cart, hit_rlen, hit_wlen, hit_stat, hit_dom;
  logic        go_rd, go_wr, cmd_abort, cmd_ack, finish;

  assign lane_m = {{8{req_be[3]}}, {8{req_be[2]}}, {8{req_be[1]}}, {8{req_be[0]}}};
  assign sel    = req_addr[4:2];

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [31:0] m);
    return (old & ~m) | (d & m);
  endfunction

  assign hit_dram  = req_wr && sel == 3'd0;
  assign hit_cart  = req_wr && sel == 3'd1;
  assign hit_rlen  = req_wr && sel == 3'd2;
  assign hit_wlen  = req_wr && sel == 3'd3;
  assign hit_stat  = req_wr && sel == 3'd4;
  assign hit_dom   = req_wr && sel == 3'd5;
  assign go_rd     = hit_rlen && !busy;
  assign go_wr     = hit_wlen && !busy;
  assign cmd_abort = hit_stat && req_be[0] && req_wdata[0];
  assign cmd_ack   = hit_stat && req_be[0] && req_wdata[1];
  assign finish    = dma_done && busy;
  assign irq       = intr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dram_addr   <= '0;
      cart_addr   <= '0;
      rd_len      <= LEN_RST;
      wr_len      <= LEN_RST;
      dom1_timing <= '0;
      busy        <= 1'b0;
      intr        <= 1'b0;
      start_rd    <= 1'b0;
      start_wr    <= 1'b0;
    end else begin
      start_rd <= go_rd;
      start_wr <= go_wr;
      if (hit_dram) dram_addr <= merge(dram_addr, req_wdata, lane_m) & DRAM_MASK;
      if (hit_cart) cart_addr <= merge(cart_addr, req_wdata, lane_m) & {31'h7FFF_FFFF, allow_odd};
      if (go_rd) rd_len <= merge({{LPAD{1'b0}}, rd_len}, req_wdata, lane_m)[LEN_W-1:0];
      if (go_wr) wr_len <= merge({{LPAD{1'b0}}, wr_len}, req_wdata, lane_m)[LEN_W-1:0];
      if (hit_dom) dom1_timing <= merge({{DPAD{1'b0}}, dom1_timing}, req_wdata, lane_m)[DOM_W-1:0];
      if (go_rd || go_wr)          busy <= 1'b1;
      else if (finish || cmd_abort) busy <= 1'b0;
      if (finish)       intr <= 1'b1;
      else if (cmd_ack) intr <= 1'b0;
    end
  end

  always_comb begin
    case (sel)
      3'd0:    rdata = dram_addr;
      3'd1:    rdata = cart_addr;
      3'd2:    rdata = {{LPAD{1'b0}}, rd_len};
      3'd3:    rdata = {{LPAD{1'b0}}, wr_len};
      3'd4:    rdata = {28'd0, intr, 1'b0, 1'b0, busy};
      3'd5:    rdata = {{DPAD{1'b0}}, dom1_timing};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pdma_regs_chk.sv
module pdma_regs_chk #(
  parameter int LEN_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_wr,
  input logic [4:0]       req_addr,
  input logic [31:0]      req_wdata,
  input logic [3:0]       req_be,
  input logic             dma_done,
  input logic             busy,
  input logic             start_rd,
  input logic             start_wr,
  input logic             irq,
  input logic [LEN_W-1:0] rd_len,
  input logic [LEN_W-1:0] wr_len
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd || start_wr) |=> !(start_rd || start_wr)); // R5
  AST_START_WITH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_rd || start_wr) |-> busy); // R5
  AST_BUSY_RLEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_wr && req_addr[4:2] == 3'd2) |=> (!start_rd && $stable(rd_len))); // R6
  AST_BUSY_WLEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_wr && req_addr[4:2] == 3'd3) |=> (!start_wr && $stable(wr_len))); // R6
  AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dma_done) |=> (irq && !busy)); // R7
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_addr[4:2] == 3'd4 && req_be[0] && req_wdata[1] && !(busy && dma_done)) |=> !irq); // R8
  AST_ABORT_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && req_addr[4:2] == 3'd4 && req_be[0] && req_wdata[0]) |=> !busy); // R9
endmodule

bind pdma_regs pdma_regs_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_addr(req_addr),
  .req_wdata(req_wdata), .req_be(req_be), .dma_done(dma_done), .busy(busy),
  .start_rd(start_rd), .start_wr(start_wr), .irq(irq), .rd_len(rd_len), .wr_len(wr_len)
);

// File: tb/pdma_regs_tb.sv
module pdma_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_wr = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        allow_odd = 1'b0;
  logic        dma_done = 1'b0;
  logic [31:0] rdata, dram_addr, cart_addr;
  logic [23:0] rd_len, wr_len;
  logic [7:0]  dom1_timing;
  logic        start_rd, start_wr, irq;

  always #10 clk = ~clk;

  pdma_regs u_dut (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .allow_odd(allow_odd), .dma_done(dma_done), .rdata(rdata),
    .dram_addr(dram_addr), .cart_addr(cart_addr), .rd_len(rd_len), .wr_len(wr_len),
    .dom1_timing(dom1_timing), .start_rd(start_rd), .start_wr(start_wr), .irq(irq)
  );

  int checks = 0, failures = 0;
  logic [31:0] m_reg [0:7];
  logic        m_busy = 1'b0, m_intr = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    return (old & ~m) | (d & m);
  endfunction

  function automatic logic [31:0] status_word();
    return {28'd0, m_intr, 2'b00, m_busy};
  endfunction

  task automatic do_write(input int r, input logic [31:0] d, input logic [3:0] be, input logic odd);
    logic e_rd = 1'b0, e_wr = 1'b0;
    @(negedge clk);
    req_wr = 1'b1; req_addr = 5'(r << 2); req_wdata = d; req_be = be; allow_odd = odd;
    case (r)
      0: m_reg[0] = merge(m_reg[0], d, be) & 32'h00FF_FFFE;
      1: m_reg[1] = merge(m_reg[1], d, be) & {31'h7FFF_FFFF, odd};
      2: if (!m_busy) begin m_reg[2] = merge(m_reg[2], d, be) & 32'hFF_FFFF; e_rd = 1'b1; m_busy = 1'b1; end
      3: if (!m_busy) begin m_reg[3] = merge(m_reg[3], d, be) & 32'hFF_FFFF; e_wr = 1'b1; m_busy = 1'b1; end
      4: if (be[0]) begin
           if (d[1]) m_intr = 1'b0;
           if (d[0]) m_busy = 1'b0;
         end
      5: m_reg[5] = merge(m_reg[5], d, be) & 32'hFF;
      default: ;
    endcase
    @(negedge clk);
    req_wr = 1'b0;
    chk("R5/R6 start_rd pulse", {31'd0, start_rd}, {31'd0, e_rd});
    chk("R5/R6 start_wr pulse", {31'd0, start_wr}, {31'd0, e_wr});
  endtask

  task automatic do_done();
    @(negedge clk);
    dma_done = 1'b1;
    if (m_busy) begin m_busy = 1'b0; m_intr = 1'b1; end
    @(negedge clk);
    dma_done = 1'b0;
    chk("R7 irq after done", {31'd0, irq}, {31'd0, m_intr});
  endtask

  task automatic check_all(input string ctx);
    string tg [0:7] = '{"R3 dram", "R4 cart", "R5 rdlen", "R5 wrlen", "R10 status", "R11 dom", "R10 unmapped6", "R10 unmapped7"};
    for (int i = 0; i < 8; i++) begin
      req_addr = 5'(i << 2);
      #1;
      chk({ctx, " ", tg[i]}, rdata, (i == 4) ? status_word() : m_reg[i]);
    end
    chk({ctx, " R8 irq"}, {31'd0, irq}, {31'd0, m_intr});
    chk({ctx, " R3 dram port"}, dram_addr, m_reg[0]);
    chk({ctx, " R4 cart port"}, cart_addr, m_reg[1]);
    chk({ctx, " R5 rd_len port"}, {8'd0, rd_len}, m_reg[2]);
    chk({ctx, " R5 wr_len port"}, {8'd0, wr_len}, m_reg[3]);
    chk({ctx, " R11 dom port"}, {24'd0, dom1_timing}, m_reg[5]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8; i++) m_reg[i] = '0;
    m_reg[2] = 32'h7F; m_reg[3] = 32'h7F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 start_rd", {31'd0, start_rd}, 32'd0);
    chk("R1 start_wr", {31'd0, start_wr}, 32'd0);
    check_all("R1 reset");

    do_write(0, 32'hFFFF_FFFF, 4'hF, 1'b0); check_all("R3 mask");
    do_write(0, 32'h0000_0000, 4'h2, 1'b0); check_all("R2 lane1 only");
    do_write(1, 32'h0000_1001, 4'hF, 1'b0); check_all("R4 even forced");
    do_write(1, 32'h0000_1001, 4'hF, 1'b1); check_all("R4 odd kept");
    do_write(5, 32'hFFFF_FFFF, 4'hF, 1'b0); check_all("R11 width");
    do_write(2, 32'hFFFF_FFFF, 4'hF, 1'b0); check_all("R5 read start");
    do_write(3, 32'h0000_0055, 4'hF, 1'b0); check_all("R6 ignored while busy");
    do_write(4, 32'h0000_0001, 4'hF, 1'b0); check_all("R9 abort");
    do_done();                              check_all("R7 done while idle");
    do_write(3, 32'h0000_0100, 4'hF, 1'b0); check_all("R5 write start");
    do_done();                              check_all("R7 done while busy");
    do_write(4, 32'h0000_0002, 4'h2, 1'b0); check_all("R8 ack without lane0");
    do_write(4, 32'h0000_0002, 4'h1, 1'b0); check_all("R8 ack");
    do_write(7, 32'hFFFF_FFFF, 4'hF, 1'b0); check_all("R10 unmapped write");

    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom % 9);
      if (op >= 7) do_done();
      else do_write(op == 6 ? 6 + int'($urandom % 2) : op, $urandom, 4'($urandom), 1'($urandom));
      check_all("R2 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule